// File: doc/BRIEF.md
# System Control and Seconds Counter

This block sits on a 32-bit word-wide register bus and gathers a handful of system-level control registers together with a settable seconds counter. Software can read and write two storage registers: an error log and an arbitration mask. Three more registers always read as zero: a version register, an I/O reset register and a power control register. Writing the shutdown command to the power control register makes the block issue a one-cycle power-off request to the platform's power sequencer.

The seconds counter is a 32-bit register that advances once per second. A prescaler divides the system clock by the parameter `TICK_DIV` to make that one-second tick. Software sets the time by writing an absolute seconds value. The counter then keeps running from that value, and the prescaler restarts at the same moment, so the first increment comes one full period after the load.

Each bus request gets a registered response in the next cycle. An access to an offset outside the decoded set completes with an error flag and no data.

Top module: `sysctl_seconds_top`

## Requirements
- R1: After reset the error log, the arbitration mask and the seconds counter are zero, and `rsp_valid` and `poweroff_req` are low.
- R2: The error log (offset 0xC004) and the arbitration mask (offset 0xC010) each store a full 32-bit word written to them and return it on read.
- R3: The version register (offset 0xC008) always reads 0x00000000, and writes to it have no effect.
- R4: A write of exactly 0x00000002 to the power control register (offset 0xC000) drives `poweroff_req` high for exactly one cycle, in the cycle after the write is accepted. Any other written value raises no request, and the register reads 0x00000000.
- R5: The I/O reset register (offset 0xC00C) always reads 0x00000000, and writes to it have no effect.
- R6: The seconds counter (offset 0x9000) increases by one every `TICK_DIV` clock cycles while it is not being written.
- R7: A write to the seconds counter loads the written value and restarts the prescaler. When the load is accepted at edge E, the counter holds value V from E onward and first reads V+1 after edge E+`TICK_DIV`.
- R8: The seconds counter wraps from 0xFFFFFFFF to 0x00000000.
- R9: An access to any other offset completes with `rsp_error` high and `rsp_rdata` zero, and changes no register.
- R10: Every request accepted at a clock edge produces `rsp_valid` high for exactly the following cycle. `rsp_rdata` carries the value a read selected as it stood at that edge, and is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the prescaler source |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A bus request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Byte offset within the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_error | output | 1 | The previous request hit an undecoded offset |
| rsp_rdata | output | 32 | Read data of the previous request |
| poweroff_req | output | 1 | One-cycle power-off request |

## Verification
On every cycle, the assertions check the following:
- one response follows each request;
- the power-off pulse lasts a single cycle and only follows the shutdown command;
- error responses carry no data;
- the version and I/O reset registers answer zero;
- the seconds counter only ever steps by one, unless a load has just been accepted, in which case it holds exactly the written word.

Some behaviours can only be shown by the bench's scenarios:
- the exact tick period and the prescaler restart on load, which the bench sweeps over read delays of up to two and a half periods;
- the wrap from all ones;
- proof that undecoded or read-only writes leave the storage registers untouched.

// File: rtl/sysctl_pkg.sv
// Package: shared register offsets, command value and register select type
// for the system control block. Offsets are byte offsets within the block.
package sysctl_pkg;
    localparam logic [31:0] OFS_SECS    = 32'h0000_9000;
    localparam logic [31:0] OFS_PWR     = 32'h0000_C000;
    localparam logic [31:0] OFS_ERRLOG  = 32'h0000_C004;
    localparam logic [31:0] OFS_VER     = 32'h0000_C008;
    localparam logic [31:0] OFS_IORST   = 32'h0000_C00C;
    localparam logic [31:0] OFS_ARB     = 32'h0000_C010;
    localparam logic [31:0] PWR_OFF_CMD = 32'h0000_0002;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PWR,
        SEL_ERRLOG,
        SEL_VER,
        SEL_IORST,
        SEL_ARB,
        SEL_SECS
    } sel_e;
endpackage

// File: rtl/sysctl_decode.sv
// Module: sysctl_decode
// Maps a byte offset onto a register select. Only the exact offsets match;
// every other address yields SEL_NONE. Assumes ADDR_W is large enough to
// hold the highest offset (0xC010 needs 16 bits).
module sysctl_decode #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    output sysctl_pkg::sel_e  sel
);
    import sysctl_pkg::*;

    localparam logic [ADDR_W-1:0] A_SECS   = ADDR_W'(OFS_SECS);
    localparam logic [ADDR_W-1:0] A_PWR    = ADDR_W'(OFS_PWR);
    localparam logic [ADDR_W-1:0] A_ERRLOG = ADDR_W'(OFS_ERRLOG);
    localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'(OFS_VER);
    localparam logic [ADDR_W-1:0] A_IORST  = ADDR_W'(OFS_IORST);
    localparam logic [ADDR_W-1:0] A_ARB    = ADDR_W'(OFS_ARB);

    // Exact-match address decode.
    always_comb begin
        case (addr)
            A_SECS:   sel = SEL_SECS;
            A_PWR:    sel = SEL_PWR;
            A_ERRLOG: sel = SEL_ERRLOG;
            A_VER:    sel = SEL_VER;
            A_IORST:  sel = SEL_IORST;
            A_ARB:    sel = SEL_ARB;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/sysctl_rwreg.sv
// Module: sysctl_rwreg
// Plain W-bit storage register with a synchronous write enable. Resets to
// zero. Assumes the write enable is already qualified by the decode.
module sysctl_rwreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold the stored word; load on write enable.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/sysctl_seconds.sv
// Module: sysctl_seconds
// Seconds counter. A prescaler divides clk by DIV to make a one-per-second
// tick, and the counter advances on that tick. A load sets the counter and
// clears the prescaler, so the next step comes DIV cycles later. A load has
// priority over a tick in the same cycle. Assumes DIV >= 1.
module sysctl_seconds #(
    parameter int DIV = 200_000_000,
    parameter int CW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count
);
    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic tick;

    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [PRE_W-1:0] pre;
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

            // Prescaler: count 0..DIV-1, restart on load.
            always_ff @(posedge clk) begin
                if (!rst_n || load)     pre <= '0;
                else if (pre == PRE_LAST) pre <= '0;
                else                    pre <= pre + PRE_W'(1);
            end

            assign tick = (pre == PRE_LAST);
        end
    endgenerate

    // Counter: load wins; otherwise step (wrapping) on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (tick)  count <= count + CW'(1);
    end
endmodule

// File: rtl/sysctl_seconds_top.sv
// Module: sysctl_seconds_top
// System control register block with seconds counter. Requests are taken
// in a single cycle; the response (valid, error, data) is registered and
// appears in the following cycle. Writing the shutdown command to the
// power control register produces a one-cycle poweroff_req. Assumes
// word-wide accesses only.
module sysctl_seconds_top #(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 32,
    parameter int TICK_DIV = 200_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_error,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              poweroff_req
);
    import sysctl_pkg::*;

    localparam logic [DATA_W-1:0] CMD_OFF = DATA_W'(PWR_OFF_CMD);

    sel_e              sel;
    logic              wr_acc;
    logic              rd_acc;
    logic              secs_load;
    logic [DATA_W-1:0] errlog_q;
    logic [DATA_W-1:0] arb_q;
    logic [DATA_W-1:0] secs_count;
    logic [DATA_W-1:0] rdata_c;

    sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    // Accepted write / read strobes.
    assign wr_acc    = req_valid &&  req_write;
    assign rd_acc    = req_valid && !req_write;
    assign secs_load = wr_acc && (sel == SEL_SECS);

    sysctl_rwreg #(.W(DATA_W)) u_errlog (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_acc && (sel == SEL_ERRLOG)),
        .d     (req_wdata),
        .q     (errlog_q)
    );

    sysctl_rwreg #(.W(DATA_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_acc && (sel == SEL_ARB)),
        .d     (req_wdata),
        .q     (arb_q)
    );

    sysctl_seconds #(.DIV(TICK_DIV), .CW(DATA_W)) u_secs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (secs_load),
        .load_val (req_wdata),
        .count    (secs_count)
    );

    // Read mux: storage registers return their value, the rest read zero.
    always_comb begin
        case (sel)
            SEL_ERRLOG: rdata_c = errlog_q;
            SEL_ARB:    rdata_c = arb_q;
            SEL_SECS:   rdata_c = secs_count;
            default:    rdata_c = '0;
        endcase
    end

    // Registered response and power-off pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_error    <= 1'b0;
            rsp_rdata    <= '0;
            poweroff_req <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_error    <= req_valid && (sel == SEL_NONE);
            rsp_rdata    <= rd_acc ? rdata_c : '0;
            poweroff_req <= wr_acc && (sel == SEL_PWR) && (req_wdata == CMD_OFF);
        end
    end
endmodule

// File: rtl/sysctl_checker.sv
// Module: sysctl_checker
// Cycle-by-cycle properties of sysctl_seconds_top, attached with bind.
// Assumes reset is held for at least one clock edge.
module sysctl_checker #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              rsp_error,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              poweroff_req,
    input logic [DATA_W-1:0] secs_count,
    input logic              secs_load
);
    import sysctl_pkg::*;

    localparam logic [ADDR_W-1:0] A_PWR   = ADDR_W'(OFS_PWR);
    localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(OFS_VER);
    localparam logic [ADDR_W-1:0] A_IORST = ADDR_W'(OFS_IORST);
    localparam logic [DATA_W-1:0] CMD_OFF = DATA_W'(PWR_OFF_CMD);

    a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r10_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        poweroff_req |=> !poweroff_req);
    a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        poweroff_req |-> $past(req_valid && req_write && req_addr == A_PWR
                               && req_wdata == CMD_OFF));
    a_r9_error_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (rsp_valid && rsp_rdata == '0));
    a_r3_version_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write && req_addr == A_VER) |->
            (rsp_rdata == '0 && !rsp_error));
    a_r5_iorst_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write && req_addr == A_IORST) |->
            (rsp_rdata == '0 && !rsp_error));
    a_r6_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(secs_count) && !$past(secs_load)) |->
            secs_count == $past(secs_count) + DATA_W'(1));
    a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        $past(secs_load) |-> secs_count == $past(req_wdata));
endmodule

bind sysctl_seconds_top sysctl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_error    (rsp_error),
    .rsp_rdata    (rsp_rdata),
    .poweroff_req (poweroff_req),
    .secs_count   (secs_count),
    .secs_load    (secs_load)
);

// File: tb/sysctl_seconds_top_tb_top.sv
`timescale 1ns/1ps
// Bench: drives requests at falling edges, samples responses at falling
// edges, with TICK_DIV = 5 so the seconds counter can be swept in full.
module sysctl_seconds_top_tb_top;
    localparam int ADDR_W = 20;
    localparam int DIV    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_error;
    logic [31:0]       rsp_rdata;
    logic              poweroff_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_seconds_top #(.ADDR_W(ADDR_W), .DATA_W(32), .TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_error(rsp_error), .rsp_rdata(rsp_rdata), .poweroff_req(poweroff_req)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: request at a falling edge, response sampled one cycle later.
    task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d, output logic [31:0] rd,
                          output bit err, output bit pwr);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd = rsp_rdata; err = rsp_error; pwr = poweroff_req;
        check(rsp_valid == 1'b1, "R10 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                          input string req);
        logic [31:0] rd; bit err; bit pwr;
        access(1'b0, a, 32'h0, rd, err, pwr);
        check(rd == exp && !err, req, rd, exp);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                      output bit pwr);
        logic [31:0] rd; bit err;
        access(1'b1, a, d, rd, err, pwr);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        bit err, pwr;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0 && poweroff_req == 1'b0, "R1 outputs idle",
              {30'b0, rsp_valid, poweroff_req}, 32'h0);
        rst_n = 1'b1;
        // R1: first read after reset sees counter 0, storage 0
        rd_chk(20'h09000, 32'h0, "R1 seconds after reset");
        rd_chk(20'h0C004, 32'h0, "R1 error log reset");
        rd_chk(20'h0C010, 32'h0, "R1 arb mask reset");
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 single-cycle rsp", {31'b0, rsp_valid}, 32'h0);

        // R2: storage patterns
        foreach (rd[i]) begin
            wr(20'h0C004, 32'h1 << i, pwr);
            wr(20'h0C010, ~(32'h1 << i), pwr);
            rd_chk(20'h0C004, 32'h1 << i, "R2 error log");
            rd_chk(20'h0C010, ~(32'h1 << i), "R2 arb mask");
        end
        wr(20'h0C004, 32'hDEAD_BEEF, pwr);
        wr(20'h0C010, 32'h1234_5678, pwr);

        // R3 / R5: read-only zero registers ignore writes
        wr(20'h0C008, 32'hFFFF_FFFF, pwr);
        rd_chk(20'h0C008, 32'h0, "R3 version");
        wr(20'h0C00C, 32'hFFFF_FFFF, pwr);
        rd_chk(20'h0C00C, 32'h0, "R5 io reset");
        rd_chk(20'h0C004, 32'hDEAD_BEEF, "R3 R5 storage untouched");

        // R4: power command
        wr(20'h0C000, 32'h2, pwr);
        check(pwr == 1'b1, "R4 pulse on command", {31'b0, pwr}, 32'h1);
        @(negedge clk);
        check(poweroff_req == 1'b0, "R4 pulse one cycle", {31'b0, poweroff_req}, 32'h0);
        for (int v = 0; v < 8; v++) begin
            if (v != 2) begin
                wr(20'h0C000, 32'(v) | ((v == 7) ? 32'h100 : 32'h0), pwr);
                check(pwr == 1'b0, "R4 no pulse other value", {31'b0, pwr}, 32'h0);
            end
        end
        wr(20'h0C000, 32'h0000_0102, pwr);
        check(pwr == 1'b0, "R4 no pulse 0x102", {31'b0, pwr}, 32'h0);
        rd_chk(20'h0C000, 32'h0, "R4 power reads zero");

        // R9: undecoded offsets
        for (int k = 0; k < 6; k++) begin
            logic [ADDR_W-1:0] a;
            case (k)
                0: a = 20'h0C014;
                1: a = 20'h00004;
                2: a = 20'h09004;
                3: a = 20'h0C002;
                4: a = 20'hFFFFF;
                default: a = 20'h1C004;
            endcase
            access(1'b1, a, 32'h2, rd, err, pwr);
            check(err == 1'b1 && pwr == 1'b0, "R9 write error", {30'b0, err, pwr}, 32'h2);
            access(1'b0, a, 32'h0, rd, err, pwr);
            check(err == 1'b1 && rd == 32'h0, "R9 read error", rd, 32'h0);
        end
        rd_chk(20'h0C004, 32'hDEAD_BEEF, "R9 error log untouched");
        rd_chk(20'h0C010, 32'h1234_5678, "R9 arb mask untouched");

        // R6 / R7: load then read after k idle cycles -> V + k/DIV
        for (int k = 0; k < 13; k++) begin
            logic [31:0] v;
            v = 32'h00AB_CDE0 + 32'(k * 16);
            wr(20'h09000, v, pwr);
            repeat (k) @(negedge clk);
            rd_chk(20'h09000, v + 32'(k / DIV), "R6 R7 count after load");
        end

        // R8: wrap from all ones
        wr(20'h09000, 32'hFFFF_FFFF, pwr);
        repeat (DIV - 1) @(negedge clk);
        rd_chk(20'h09000, 32'hFFFF_FFFF, "R8 before wrap");
        wr(20'h09000, 32'hFFFF_FFFF, pwr);
        repeat (DIV) @(negedge clk);
        rd_chk(20'h09000, 32'h0, "R8 wrap to zero");

        // R6: free running across several periods
        wr(20'h09000, 32'h100, pwr);
        repeat (4 * DIV + 2) @(negedge clk);
        rd_chk(20'h09000, 32'h104, "R6 free run");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule